// File: doc/BRIEF.md
# Line-Fill Tracker with Ordered Pend Queue

This block sits between a data cache and external memory and keeps track of every line read that is still in flight: cacheable line fills and non-cacheable reads, each fetching one 32-byte line. A request that misses the tracker claims a free fill slot, and the block issues one memory read for that line. When the line comes back, it is presented on a delivery port so the cache can install it or hand it to the requester.

A cacheable load or store whose line is already being fetched does not start a second read. It is parked in a small queue that records the slot it waits on, the word it touches, and, for a store, its 32-bit data. Parked operations are replayed on a completion port strictly in the order they arrived, one per cycle. A parked operation leaves the queue only once its line has arrived and every older parked operation has left. A fill slot is released only when its line has arrived and no parked operation still points at it.

The primary access of a miss is resolved by the cache from the delivered line. Cache array writes and address translation are outside this block.

Top module: `fill_pend_tracker`

## Requirements
- R1: After reset, mem_req_valid, cpl_valid and line_valid are 0, and a presented request of either kind sees req_ready = 1.
- R2: A request that matches no slot takes the lowest free slot. Exactly one memory read is issued for it, with mem_req_id equal to the slot index and mem_req_addr equal to req_addr bits [31:5]. At most four slots are busy at once. While all four are busy, a non-matching request sees req_ready = 0.
- R3: A request with req_cacheable = 0 always takes a new slot. Its slot is never matched by a later request, so a cacheable access to the same line issues its own memory read.
- R4: A cacheable request whose line (req_addr[31:5]) equals that of a busy cacheable slot is parked and issues no memory read.
- R5: With four operations parked, a further matching request sees req_ready = 0 until one retires.
- R6: In the cycle mem_rsp_valid is high, line_valid is high, line_id equals mem_rsp_id, line_addr equals that slot's line address, line_data equals mem_rsp_data, and line_noncache is that slot's non-cacheable flag.
- R7: Parked operations retire in arrival order, at most one per cycle, and never before the response for their slot. A younger operation whose line has arrived waits for all older ones.
- R8: A retiring operation shows cpl_addr = {line, word index req_addr[4:2], 2'b00} and cpl_store. For a store, cpl_wdata is the word it carried. For a load, cpl_rdata is bits [32k+31:32k] of the returned line, where k is the word index.
- R9: A slot frees in the cycle after its line has arrived and no parked operation refers to it. A new miss can then take it.
- R10: While mem_req_valid is high and mem_req_ready is low, mem_req_valid, mem_req_addr and mem_req_id hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Cache request present |
| req_ready | output | 1 | Request accepted this cycle; low is a stall |
| req_addr | input | 32 | Byte address of the access |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_cacheable | input | 1 | 0 marks a non-cacheable read |
| req_wdata | input | 32 | Store data |
| mem_req_valid | output | 1 | Line read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 27 | Line address |
| mem_req_id | output | 2 | Slot index tagging the read |
| mem_rsp_valid | input | 1 | Line data returning |
| mem_rsp_id | input | 2 | Slot the data belongs to |
| mem_rsp_data | input | 256 | Returned line, word 0 in the low bits |
| line_valid | output | 1 | Line delivered to the cache |
| line_id | output | 2 | Slot of the delivered line |
| line_addr | output | 27 | Line address of the delivered line |
| line_noncache | output | 1 | Delivered line was a non-cacheable read |
| line_data | output | 256 | Delivered line data |
| cpl_valid | output | 1 | A parked operation retires |
| cpl_store | output | 1 | Retiring operation is a store |
| cpl_addr | output | 32 | Word address of the retiring operation |
| cpl_wdata | output | 32 | Store word of the retiring operation |
| cpl_rdata | output | 32 | Loaded word of the retiring operation |

## Verification
The hardest state to reach is a full queue whose entries point at slots in an arbitrary pattern, with lines returning in an order unrelated to arrival order. Only that state shows whether a young operation with a returned line waits behind an old one whose line is still missing. The stimulus fills all four slots and then parks four operations. Their slot choice is drawn from every one of the 256 patterns. Lines are returned in rotated or reversed orders, and after each return the count of retired operations is compared with the length of the arrival-ordered prefix whose lines have all arrived.

// File: rtl/fill_pend_tracker.sv
module fill_pend_tracker #(
  parameter int FILL_N     = 4,
  parameter int PEND_N     = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_W     = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic                                   req_store,
  input  logic                                   req_cacheable,
  input  logic [WORD_W-1:0]                      req_wdata,
  output logic                                   mem_req_valid,
  input  logic                                   mem_req_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_req_addr,
  output logic [$clog2(FILL_N)-1:0]              mem_req_id,
  input  logic                                   mem_rsp_valid,
  input  logic [$clog2(FILL_N)-1:0]              mem_rsp_id,
  input  logic [LINE_BYTES*8-1:0]                mem_rsp_data,
  output logic                                   line_valid,
  output logic [$clog2(FILL_N)-1:0]              line_id,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   line_addr,
  output logic                                   line_noncache,
  output logic [LINE_BYTES*8-1:0]                line_data,
  output logic                                   cpl_valid,
  output logic                                   cpl_store,
  output logic [ADDR_W-1:0]                      cpl_addr,
  output logic [WORD_W-1:0]                      cpl_wdata,
  output logic [WORD_W-1:0]                      cpl_rdata
);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int LA_W     = ADDR_W - OFF_W;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WSEL_W   = OFF_W - BYTE_OFF;
  localparam int FID_W    = $clog2(FILL_N);
  localparam int PID_W    = $clog2(PEND_N);

  logic [FILL_N-1:0] f_vld, f_iss, f_done, f_nc;
  logic [LA_W-1:0]   f_line [FILL_N];
  logic [LINE_W-1:0] f_data [FILL_N];

  logic [PEND_N-1:0] p_vld;
  logic [FID_W-1:0]  p_fid  [PEND_N];
  logic [WSEL_W-1:0] p_wsel [PEND_N];
  logic [PEND_N-1:0] p_st;
  logic [WORD_W-1:0] p_wd   [PEND_N];
  logic [PID_W-1:0]  head, tail;

  logic [LA_W-1:0]   req_line;
  logic [FILL_N-1:0] hit_vec, refd, free_now;
  logic [FID_W-1:0]  hit_id, free_id, iss_id;
  logic              hit, any_free, any_iss, acc, push, alloc, pop, iss_ld;

  assign req_line = req_addr[ADDR_W-1:OFF_W];

  always_comb begin
    hit_id = '0; free_id = '0; iss_id = '0;
    any_free = 1'b0; any_iss = 1'b0;
    for (int i = FILL_N-1; i >= 0; i--) begin
      hit_vec[i] = f_vld[i] && !f_nc[i] && req_cacheable && f_line[i] == req_line;
      if (hit_vec[i]) hit_id = FID_W'(i);
      if (!f_vld[i]) begin free_id = FID_W'(i); any_free = 1'b1; end
      if (f_vld[i] && !f_iss[i]) begin iss_id = FID_W'(i); any_iss = 1'b1; end
    end
  end

  assign hit       = |hit_vec;
  assign req_ready = hit ? !(&p_vld) : any_free;
  assign acc       = req_valid && req_ready;
  assign push      = acc && hit;
  assign alloc     = acc && !hit;
  assign pop       = p_vld[head] && f_done[p_fid[head]];
  assign iss_ld    = any_iss && (!mem_req_valid || mem_req_ready);

  always_comb begin
    for (int i = 0; i < FILL_N; i++) begin
      refd[i] = push && hit_id == FID_W'(i);
      for (int s = 0; s < PEND_N; s++)
        if (p_vld[s] && p_fid[s] == FID_W'(i)) refd[i] = 1'b1;
      free_now[i] = f_vld[i] && f_done[i] && !refd[i];
    end
  end

  assign line_valid    = mem_rsp_valid;
  assign line_id       = mem_rsp_id;
  assign line_addr     = f_line[mem_rsp_id];
  assign line_noncache = f_nc[mem_rsp_id];
  assign line_data     = mem_rsp_data;

  assign cpl_valid = pop;
  assign cpl_store = p_st[head];
  assign cpl_addr  = {f_line[p_fid[head]], p_wsel[head], BYTE_OFF'(0)};
  assign cpl_wdata = p_wd[head];
  assign cpl_rdata = f_data[p_fid[head]][WORD_W*32'(p_wsel[head]) +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_vld <= '0; f_iss <= '0; f_done <= '0; f_nc <= '0;
      p_vld <= '0; head <= '0; tail <= '0;
      mem_req_valid <= 1'b0; mem_req_addr <= '0; mem_req_id <= '0;
    end else begin
      for (int i = 0; i < FILL_N; i++) begin
        if (free_now[i]) f_vld[i] <= 1'b0;
        if (alloc && free_id == FID_W'(i)) begin
          f_vld[i] <= 1'b1; f_iss[i] <= 1'b0; f_done[i] <= 1'b0;
          f_nc[i] <= !req_cacheable;
        end
        if (iss_ld && iss_id == FID_W'(i)) f_iss[i] <= 1'b1;
        if (mem_rsp_valid && mem_rsp_id == FID_W'(i)) f_done[i] <= 1'b1;
      end
      if (iss_ld) begin
        mem_req_valid <= 1'b1;
        mem_req_addr  <= f_line[iss_id];
        mem_req_id    <= iss_id;
      end else if (mem_req_ready) begin
        mem_req_valid <= 1'b0;
      end
      if (push) begin
        p_vld[tail] <= 1'b1;
        tail <= (tail == PID_W'(PEND_N-1)) ? '0 : tail + 1'b1;
      end
      if (pop) begin
        p_vld[head] <= 1'b0;
        head <= (head == PID_W'(PEND_N-1)) ? '0 : head + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) f_line[free_id] <= req_line;
    if (mem_rsp_valid) f_data[mem_rsp_id] <= mem_rsp_data;
    if (push) begin
      p_fid[tail]  <= hit_id;
      p_wsel[tail] <= req_addr[BYTE_OFF +: WSEL_W];
      p_st[tail]   <= req_store;
      p_wd[tail]   <= req_wdata;
    end
  end

  AST_RSP_FOR_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> f_vld[mem_rsp_id] && f_iss[mem_rsp_id] && !f_done[mem_rsp_id]); // R6
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_id)); // R10
  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !(mem_req_valid && mem_req_id == $past(mem_req_id))); // R2
  AST_PEND_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !p_vld[tail]); // R5
  AST_CPL_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !p_vld[$past(head)] || $past(push && head == tail)); // R7

  for (genvar g = 0; g < FILL_N; g++) begin : g_free_chk
    AST_FREE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f_vld[g]) |-> $past(f_done[g])); // R9
  end
endmodule

// File: tb/fill_pend_tracker_tb.sv
`timescale 1ns/1ps
module fill_pend_tracker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_store = 0, req_cacheable = 0, req_ready;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic mem_req_valid, mem_req_ready = 0;
  logic [26:0] mem_req_addr;
  logic [1:0] mem_req_id;
  logic mem_rsp_valid = 0;
  logic [1:0] mem_rsp_id = 0;
  logic [255:0] mem_rsp_data = 0;
  logic line_valid, line_noncache;
  logic [1:0] line_id;
  logic [26:0] line_addr;
  logic [255:0] line_data;
  logic cpl_valid, cpl_store;
  logic [31:0] cpl_addr, cpl_wdata, cpl_rdata;

  fill_pend_tracker u_dut (.*);

  int checks = 0, fails = 0, cpl_seen = 0, exp_n = 0, iss_n = 0;
  logic [31:0] exp_addr [2048];
  logic [31:0] exp_data [2048];
  logic        exp_st   [2048];
  logic [26:0] fline    [4];
  logic [1:0]  iss_id_log   [2048];
  logic [26:0] iss_line_log [2048];

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [255:0] ldata(input logic [26:0] ln);
    logic [255:0] d;
    for (int k = 0; k < 8; k++) d[32*k +: 32] = (32'(ln) * 8 + 32'(k)) ^ 32'h5A00_0000;
    return d;
  endfunction

  always @(negedge clk) if (rst_n && mem_req_valid && mem_req_ready) begin
    iss_id_log[iss_n] = mem_req_id; iss_line_log[iss_n] = mem_req_addr;
    fline[mem_req_id] = mem_req_addr; iss_n++;
  end

  always @(negedge clk) if (rst_n && cpl_valid) begin
    chk(cpl_seen < exp_n, "R7 unexpected retire", 256'(cpl_seen), 256'(exp_n));
    chk(cpl_addr == exp_addr[cpl_seen], "R8 cpl_addr", 256'(cpl_addr), 256'(exp_addr[cpl_seen]));
    chk(cpl_store == exp_st[cpl_seen], "R8 cpl_store", 256'(cpl_store), 256'(exp_st[cpl_seen]));
    if (exp_st[cpl_seen]) chk(cpl_wdata == exp_data[cpl_seen], "R8 store word", 256'(cpl_wdata), 256'(exp_data[cpl_seen]));
    else chk(cpl_rdata == exp_data[cpl_seen], "R8 load word", 256'(cpl_rdata), 256'(exp_data[cpl_seen]));
    cpl_seen++;
  end

  task automatic send(input logic [31:0] a, input logic st, input logic c, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_store = st; req_cacheable = c; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic probe(input logic [31:0] a, input logic c, input logic exp_rdy, input string req);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_store = 0; req_cacheable = c; req_wdata = 0;
    #1 chk(req_ready == exp_rdy, req, 256'(req_ready), 256'(exp_rdy));
    req_valid = 0;
  endtask

  task automatic respond(input logic [1:0] id);
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_id = id; mem_rsp_data = ldata(fline[id]);
    #1;
    chk(line_valid && line_id == id, "R6 line_valid/id", {line_valid, 2'(line_id)}, {1'b1, id});
    chk(line_addr == fline[id], "R6 line_addr", 256'(line_addr), 256'(fline[id]));
    chk(line_data == ldata(fline[id]), "R6 line_data", line_data, ldata(fline[id]));
    @(posedge clk); #1 mem_rsp_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !cpl_valid && !line_valid, "R1 reset outputs",
        {mem_req_valid, cpl_valid, line_valid}, 0);
    rst_n = 1;
    probe(32'h100, 1, 1, "R1 ready after reset");
    probe(32'h100, 0, 1, "R1 ready after reset nc");

    for (int r = 0; r < 256; r++) begin
      int base_iss, base_cpl;
      logic [26:0] bl;
      logic [3:0] ret;
      bl = 27'(1000 + r * 4);
      base_iss = iss_n; base_cpl = cpl_seen;
      mem_req_ready = (r != 0);
      probe({bl, 5'd0}, 1, 1, "R9 freed slots accept miss");
      for (int i = 0; i < 4; i++) send({bl + 27'(i), 5'(4 * i)}, i[0], 1, 0);
      if (r == 0) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == bl && mem_req_id == 0, "R10 request shown",
            {mem_req_valid, mem_req_id, mem_req_addr}, {1'b1, 2'd0, bl});
        repeat (2) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == bl && mem_req_id == 0, "R10 request held",
            {mem_req_valid, mem_req_id, mem_req_addr}, {1'b1, 2'd0, bl});
        mem_req_ready = 1;
      end
      repeat (6) @(negedge clk);
      chk(iss_n - base_iss == 4, "R2 four reads issued", 256'(iss_n - base_iss), 4);
      for (int i = 0; i < 4; i++)
        chk(iss_id_log[base_iss + i] == 2'(i) && iss_line_log[base_iss + i] == bl + 27'(i),
            "R2 slot/line order", {iss_id_log[base_iss + i], iss_line_log[base_iss + i]},
            {2'(i), bl + 27'(i)});
      probe({bl + 27'd50, 5'd0}, 1, 0, "R2 fifth miss stalls");
      for (int j = 0; j < 4; j++) begin
        logic [1:0] f; logic [2:0] w; logic st; logic [31:0] d;
        f = 2'((r >> (2 * j)) & 3); w = 3'((r + 3 * j) & 7);
        st = 1'((r >> j) & 1) ^ 1'(j & 1);
        d = 32'hC000_0000 | (32'(r) << 8) | 32'(j);
        exp_addr[exp_n] = {bl + 27'(f), w, 2'b00}; exp_st[exp_n] = st;
        exp_data[exp_n] = st ? d : ldata(bl + 27'(f))[32 * w +: 32];
        exp_n++;
        send({bl + 27'(f), w, 2'b00}, st, 1, d);
      end
      probe({bl + 27'd1, 5'd4}, 1, 0, "R5 full queue stalls hit");
      repeat (3) @(negedge clk);
      chk(iss_n - base_iss == 4 && !mem_req_valid, "R4 hits issue no read",
          256'(iss_n - base_iss), 4);
      ret = 0;
      for (int k = 0; k < 4; k++) begin
        int id, pre;
        id = r[0] ? ((3 - k + r) % 4) : ((k + r) % 4);
        respond(2'(id));
        ret[id] = 1;
        pre = 0;
        for (int j = 0; j < 4; j++) begin
          if (pre == j && ret[(r >> (2 * j)) & 3]) pre = j + 1;
        end
        repeat (6) @(negedge clk);
        chk(cpl_seen - base_cpl == pre, "R7 in-order retire count",
            256'(cpl_seen - base_cpl), 256'(pre));
      end
      repeat (2) @(negedge clk);
    end

    begin
      int b0, c0;
      b0 = iss_n; c0 = cpl_seen;
      send({27'd9000, 5'd0}, 0, 0, 0);
      send({27'd9000, 5'd8}, 1, 1, 32'h1234);
      repeat (6) @(negedge clk);
      chk(iss_n - b0 == 2, "R3 nc slot not matched", 256'(iss_n - b0), 2);
      @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_id = iss_id_log[b0]; mem_rsp_data = ldata(27'd9000);
      #1 chk(line_noncache == 1, "R3 nc flag on delivery", 256'(line_noncache), 1);
      @(posedge clk); #1 mem_rsp_valid = 0;
      respond(iss_id_log[b0 + 1]);
      repeat (4) @(negedge clk);
      chk(cpl_seen == c0, "R3 nothing parked", 256'(cpl_seen), 256'(c0));
      probe({27'd9100, 5'd0}, 1, 1, "R9 slots free after delivery");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule